// File: doc/BRIEF.md
# Gate Driver Enable and Thermal Supervisor

This block decides whether a half-bridge gate driver may switch. It watches three things. The first is a supply-voltage code. The second is a die-temperature code. The third is an active-low disable pin, which comes with a separate indication that the pin is floating. From these it produces one registered driver-enable. Downstream gate sequencing uses that enable to hold both the high-side and the low-side gate commands low whenever it is deasserted.

Supply undervoltage, thermal warning and thermal shutdown each keep their own hysteresis state. Each state updates only on a sample-valid strobe. The thermal warning is also brought out as an active-low flag, meant to be used as an open-drain output. Every rising edge of the synchronised pin produces a one-cycle recalibration pulse for the zero-current threshold, but only while lockout and shutdown are both clear. All thresholds are parameters in code units.

Top module: `drv_enable_supervisor`

## Requirements
- R1: After reset, lockout, warning and shutdown are all set. drv_en is 0, warn_n is 0 and recal is 0, and drv_en stays 0 until valid samples clear lockout and shutdown.
- R2: A valid supply sample above UV_RISE (default 174) clears lockout, and a valid sample below UV_FALL (default 164) sets it. A sample between the two thresholds changes nothing. While lockout is set, drv_en is 0.
- R3: The effective pin is high only when dis_n_pin is 1 and pin_float is 0. A low pin or a floating pin disables the driver. A change of the effective pin reaches drv_en after 2 to 3 clock edges, through a two-flop synchroniser and the output register.
- R4: A valid temperature sample at or above WARN_SET (default 150) drives warn_n to 0. A valid sample at or below WARN_CLR (default 135) drives warn_n to 1. Any other sample leaves warn_n unchanged.
- R5: A valid temperature sample above SD_SET (default 180) sets shutdown, and a valid sample below SD_CLR (default 155) clears it. While shutdown is set, drv_en is 0, and warn_n is 0 as well.
- R6: drv_en is 1 exactly when, in the previous cycle, the synchronised pin was high and lockout and shutdown were both clear. A sample strobed at one edge therefore shows on drv_en at the next edge.
- R7: recal is a one-cycle pulse, issued in the same cycle in which drv_en rises because the synchronised pin rose, and only if lockout and shutdown are both clear. No pulse is issued when drv_en rises because lockout or shutdown cleared while the pin was already high, and none is issued for a pin rise during lockout or shutdown.
- R8: Codes presented while their valid strobe is 0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsup_code | input | W | Supply-voltage code |
| vsup_vld | input | 1 | Supply code valid strobe |
| temp_code | input | W | Die-temperature code |
| temp_vld | input | 1 | Temperature code valid strobe |
| dis_n_pin | input | 1 | Disable pin, low disables |
| pin_float | input | 1 | High when the disable pin is floating |
| drv_en | output | 1 | Driver may switch; gates held low when 0 |
| warn_n | output | 1 | Thermal warning flag, active low |
| recal | output | 1 | One-cycle zero-current recalibration pulse |

## Verification
A wrong hysteresis state shows on drv_en or warn_n. A lockout or shutdown state that is set or cleared at the wrong threshold moves drv_en one edge after the deciding sample. A warning state with the wrong threshold moves warn_n at the sampling edge itself. A fault in the synchroniser shifts the pin-to-enable latency away from its fixed value, so the cycle-exact reference comparison catches it within one cycle of the pin change. A fault in the edge qualification shows as a recal pulse that is missing or extra, either on a pin rise during lockout or shutdown or when lockout or shutdown clears with the pin already high.

// File: rtl/drv_enable_supervisor.sv
module drv_enable_supervisor #(
  parameter int W = 8,
  parameter logic [W-1:0] UV_RISE  = 8'd174,
  parameter logic [W-1:0] UV_FALL  = 8'd164,
  parameter logic [W-1:0] WARN_SET = 8'd150,
  parameter logic [W-1:0] WARN_CLR = 8'd135,
  parameter logic [W-1:0] SD_SET   = 8'd180,
  parameter logic [W-1:0] SD_CLR   = 8'd155,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] vsup_code,
  input  logic         vsup_vld,
  input  logic [W-1:0] temp_code,
  input  logic         temp_vld,
  input  logic         dis_n_pin,
  input  logic         pin_float,
  output logic         drv_en,
  output logic         warn_n,
  output logic         recal
);
  logic          uv_q, warn_q, sd_q;
  logic [SYNC:0] sync_q;
  logic          pin_s, pin_prev, clear_ok;

  assign pin_s    = sync_q[SYNC-1];
  assign pin_prev = sync_q[SYNC];
  assign clear_ok = ~uv_q & ~sd_q;
  assign warn_n   = ~warn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) uv_q <= 1'b1;
    else if (vsup_vld) begin
      if (uv_q && vsup_code > UV_RISE) uv_q <= 1'b0;
      else if (!uv_q && vsup_code < UV_FALL) uv_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      warn_q <= 1'b1;
      sd_q   <= 1'b1;
    end else if (temp_vld) begin
      if (temp_code >= WARN_SET) warn_q <= 1'b1;
      else if (temp_code <= WARN_CLR) warn_q <= 1'b0;
      if (temp_code > SD_SET) sd_q <= 1'b1;
      else if (temp_code < SD_CLR) sd_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      drv_en <= 1'b0;
      recal  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-1:0], dis_n_pin & ~pin_float};
      drv_en <= pin_s & clear_ok;
      recal  <= pin_s & ~pin_prev & clear_ok;
    end
  end
endmodule

// File: rtl/drv_enable_supervisor_chk.sv
module drv_enable_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic temp_vld,
  input logic drv_en,
  input logic warn_n,
  input logic recal,
  input logic uv_q,
  input logic sd_q
);
  AST_UV_BLOCKS_EN: assert property (@(posedge clk) disable iff (!rst_n) uv_q |=> !drv_en); // R2
  AST_SD_BLOCKS_EN: assert property (@(posedge clk) disable iff (!rst_n) sd_q |=> !drv_en); // R5
  AST_SD_WITH_WARN: assert property (@(posedge clk) disable iff (!rst_n) sd_q |-> !warn_n); // R5
  AST_WARN_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) !temp_vld |=> $stable(warn_n)); // R4
  AST_RECAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) recal |=> !recal); // R7
  AST_RECAL_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n) recal |-> drv_en); // R7
endmodule

bind drv_enable_supervisor drv_enable_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .temp_vld(temp_vld), .drv_en(drv_en),
  .warn_n(warn_n), .recal(recal), .uv_q(uv_q), .sd_q(sd_q)
);

// File: tb/sim_drv_enable_supervisor.sv
`timescale 1ns/1ps
module sim_drv_enable_supervisor;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] vsup_code = '0, temp_code = '0;
  logic vsup_vld = 1'b0, temp_vld = 1'b0, dis_n_pin = 1'b0, pin_float = 1'b0;
  logic drv_en, warn_n, recal;
  int n_chk = 0, n_bad = 0, n_pulse = 0;
  bit done = 0;

  always #4 clk = ~clk;

  drv_enable_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .vsup_code(vsup_code), .vsup_vld(vsup_vld),
    .temp_code(temp_code), .temp_vld(temp_vld), .dis_n_pin(dis_n_pin),
    .pin_float(pin_float), .drv_en(drv_en), .warn_n(warn_n), .recal(recal)
  );

  bit m_uv, m_w, m_sd, m_en, m_rc;
  bit hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_uv = 1; m_w = 1; m_sd = 1; m_en = 0; m_rc = 0;
      hist = '{0, 0, 0};
    end else begin
      m_en = hist[1] && !m_uv && !m_sd;
      m_rc = hist[1] && !hist[2] && !m_uv && !m_sd;
      if (vsup_vld) begin
        if (m_uv && vsup_code > 174) m_uv = 0;
        else if (!m_uv && vsup_code < 164) m_uv = 1;
      end
      if (temp_vld) begin
        if (temp_code >= 150) m_w = 1;
        else if (temp_code <= 135) m_w = 0;
        if (temp_code > 180) m_sd = 1;
        else if (temp_code < 155) m_sd = 0;
      end
      hist.push_front(dis_n_pin && !pin_float);
      void'(hist.pop_back());
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R6 drv_en per cycle", drv_en, m_en);
    chk("R4 warn_n per cycle", warn_n, !m_w);
    chk("R7 recal per cycle", recal, m_rc);
    if (recal) n_pulse++;
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic vs(int c);
    @(negedge clk); vsup_code = 8'(c); vsup_vld = 1;
    @(negedge clk); vsup_vld = 0;
  endtask

  task automatic ts(int c);
    @(negedge clk); temp_code = 8'(c); temp_vld = 1;
    @(negedge clk); temp_vld = 0;
  endtask

  task automatic pin(bit v);
    @(negedge clk); dis_n_pin = v;
  endtask

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int p0;
    tick(3);
    chk("R1 reset drv_en", drv_en, 0);
    chk("R1 reset warn_n", warn_n, 0);
    chk("R1 reset recal", recal, 0);
    rst_n = 1;
    pin(1); tick(6);
    chk("R1 no samples keeps drv_en low", drv_en, 0);
    vs(170); tick(3);
    chk("R2 between thresholds keeps lockout", drv_en, 0);
    vs(175); ts(100); tick(4);
    chk("R2 supply above rise clears lockout", drv_en, 1);
    chk("R4 low temperature releases warning", warn_n, 1);
    chk("R7 no pulse when lockout clears with pin high", n_pulse, 0);
    pin(0); tick(1);
    chk("R3 pin low not yet seen after one edge", drv_en, 1);
    tick(3);
    chk("R3 pin low disables", drv_en, 0);
    p0 = n_pulse;
    pin(1); tick(5);
    chk("R3 pin high enables", drv_en, 1);
    chk("R7 one pulse on pin rise", n_pulse - p0, 1);
    @(negedge clk); pin_float = 1; tick(4);
    chk("R3 floating pin disables", drv_en, 0);
    @(negedge clk); pin_float = 0; tick(4);
    ts(150); tick(1);
    chk("R4 warning sets at threshold", warn_n, 0);
    ts(140); tick(1);
    chk("R4 warning holds inside band", warn_n, 0);
    ts(135); tick(1);
    chk("R4 warning releases at clear threshold", warn_n, 1);
    ts(149); tick(1);
    chk("R4 below set threshold no warning", warn_n, 1);
    ts(180); tick(2);
    chk("R5 at shutdown threshold still enabled", drv_en, 1);
    ts(181); tick(2);
    chk("R5 shutdown disables", drv_en, 0);
    chk("R5 shutdown implies warning", warn_n, 0);
    p0 = n_pulse;
    pin(0); tick(4); pin(1); tick(5);
    chk("R7 no pulse during shutdown", n_pulse - p0, 0);
    ts(155); tick(3);
    chk("R5 shutdown holds at clear threshold", drv_en, 0);
    ts(154); tick(3);
    chk("R5 shutdown clears below threshold", drv_en, 1);
    chk("R4 warning still set at 154", warn_n, 0);
    @(negedge clk); vsup_code = 8'd0; temp_code = 8'd255; tick(5);
    chk("R8 unstrobed codes ignored drv_en", drv_en, 1);
    chk("R8 unstrobed codes ignored warn_n", warn_n, 0);
    vs(164); tick(3);
    chk("R2 at fall threshold stays unlocked", drv_en, 1);
    vs(163); tick(3);
    chk("R2 below fall threshold locks out", drv_en, 0);
    p0 = n_pulse;
    pin(0); tick(4); pin(1); tick(5);
    chk("R7 no pulse during lockout", n_pulse - p0, 0);
    vs(174); tick(3);
    chk("R2 at rise threshold stays locked", drv_en, 0);
    vs(200); tick(3);
    chk("R6 enable after lockout clears", drv_en, 1);
    tick(4);
    finish_run();
  end
endmodule